// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block rearranges the elements of a short vector under the control of a per-element mask. It has two operations. In compress mode, the elements whose mask bit is set are packed into the low positions of the result. Their ascending order is kept, and the number of packed elements is reported. In expand mode, the low elements of a packed source are dealt out in order to the positions whose mask bit is set. Every other position takes the element with the same index from a fill vector.

A pulse on `start` launches an operation, and all operands are captured at that edge. The unit then visits one element per clock, so a result is ready after `NUM_ELEM` cycles. Only the first `vec_len` mask bits take part in the operation.

The controller has three states, `ST_IDLE`, `ST_RUN` and `ST_DONE`, with these transitions:

| From | To | Condition |
|------|----|-----------|
| `ST_IDLE` | `ST_RUN` | `start` |
| `ST_RUN` | `ST_DONE` | last element index |
| `ST_DONE` | `ST_RUN` | `start` (back-to-back) |
| `ST_DONE` | `ST_IDLE` | no `start` |

In every other case the state holds.

Top module: `vmask_permute`

## Requirements
- R1: In compress mode (`op_sel`=0), the elements whose mask bit is set take result positions 0, 1, 2 and onward, in ascending source order. Element i sits at bits [i*ELEM_W +: ELEM_W] of every vector port.
- R2: In compress mode, every result position at or above the packed length is zero.
- R3: In both modes, `packed_len` equals the number of set mask bits that take part in the operation.
- R4: In expand mode (`op_sel`=1), the k-th set mask position (counting from index 0) receives source element k.
- R5: In expand mode, each position whose mask bit is clear or excluded receives the `fill_vec` element at the same index.
- R6: Mask bits at index `vec_len` and above are ignored. A `vec_len` of `NUM_ELEM` or more uses the whole mask.
- R7: `done` is high for exactly one cycle. It rises after the `NUM_ELEM`-th rising edge that follows the edge accepting `start`.
- R8: A `start` that arrives while the controller is in `ST_RUN` is ignored. The running operation's result and its timing are unchanged.
- R9: A `start` given in the cycle where `done` is high is accepted, and a new operation begins at that edge.
- R10: After reset, `done` is 0, `result` is all zero and `packed_len` is 0.
- R11: An all-zero mask gives `packed_len` 0. Compress then yields an all-zero result, and expand yields `fill_vec` unchanged.
- R12: `result` and `packed_len` hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation; operands are captured on the accepting edge |
| op_sel | input | 1 | 0 = compress, 1 = expand |
| vec_len | input | LEN_W | Number of leading mask bits that take part |
| mask | input | NUM_ELEM | One select bit per element |
| src_vec | input | NUM_ELEM*ELEM_W | Source vector (packed source in expand mode) |
| fill_vec | input | NUM_ELEM*ELEM_W | Values for unselected positions in expand mode |
| result | output | NUM_ELEM*ELEM_W | Rearranged vector |
| packed_len | output | LEN_W | Count of participating set mask bits |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse and a fresh `start`, and separately a `start` and an operation still in progress. The bench provokes the first case by raising `start` in the very cycle where `done` is observed high. The second operation must then complete exactly `NUM_ELEM` edges later with its own data. The bench provokes the second case by pulsing `start` with different operands a few cycles into a run, and the first operation's result and timing must come out untouched. A behavioural model built from queues judges both cases, and its expected `done` and result are compared with the design on every clock.

// File: rtl/vmp_pkg.sv
`timescale 1ns/1ps
package vmp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vmp_state_e;

    typedef enum logic {
        OP_COMPRESS = 1'b0,
        OP_EXPAND   = 1'b1
    } vmp_op_e;
endpackage

// File: rtl/vmp_ctrl.sv
`timescale 1ns/1ps
module vmp_ctrl
    import vmp_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             running,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEM - 1);

    vmp_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // element index walks 0..NUM_ELEM-1 while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx_q <= '0;
        else if (load) idx_q <= '0;
        else if (step) idx_q <= idx_q + IDX_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (idx_q == LAST_IDX) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        done    = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step    = 1'b1;
                running = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

    assign idx = idx_q;
endmodule

// File: rtl/vmp_vl_mask.sv
`timescale 1ns/1ps
module vmp_vl_mask #(
    parameter int NUM_ELEM = 8,
    localparam int LEN_W = $clog2(NUM_ELEM + 1)
) (
    input  logic [LEN_W-1:0]    vec_len,
    input  logic [NUM_ELEM-1:0] mask,
    output logic [NUM_ELEM-1:0] eff_mask
);
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_bit
        assign eff_mask[g] = mask[g] & (vec_len > LEN_W'(g));
    end
endmodule

// File: rtl/vmp_datapath.sv
`timescale 1ns/1ps
module vmp_datapath
    import vmp_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 16,
    localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int LEN_W = $clog2(NUM_ELEM + 1),
    localparam int VEC_W = NUM_ELEM * ELEM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [IDX_W-1:0]    idx,
    input  vmp_op_e             op_in,
    input  logic [NUM_ELEM-1:0] eff_mask,
    input  logic [VEC_W-1:0]    src_flat,
    input  logic [VEC_W-1:0]    fill_flat,
    output logic [VEC_W-1:0]    result_flat,
    output logic [LEN_W-1:0]    packed_len
);
    logic [ELEM_W-1:0]   src_q [NUM_ELEM];
    logic [ELEM_W-1:0]   res_q [NUM_ELEM];
    logic [NUM_ELEM-1:0] emask_q;
    logic [LEN_W-1:0]    cnt_q;
    vmp_op_e             op_q;
    logic [IDX_W-1:0]    cnt_idx;

    assign cnt_idx = cnt_q[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_COMPRESS;
            emask_q <= '0;
            cnt_q   <= '0;
            for (int e = 0; e < NUM_ELEM; e++) begin
                src_q[e] <= '0;
                res_q[e] <= '0;
            end
        end else if (load) begin
            op_q    <= op_in;
            emask_q <= eff_mask;
            cnt_q   <= '0;
            for (int e = 0; e < NUM_ELEM; e++) begin
                src_q[e] <= src_flat[e*ELEM_W +: ELEM_W];
                res_q[e] <= (op_in == OP_EXPAND) ? fill_flat[e*ELEM_W +: ELEM_W] : '0;
            end
        end else if (step && emask_q[idx]) begin
            if (op_q == OP_COMPRESS) res_q[cnt_idx] <= src_q[idx];
            else                     res_q[idx]     <= src_q[cnt_idx];
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_out
        assign result_flat[g*ELEM_W +: ELEM_W] = res_q[g];
    end

    assign packed_len = cnt_q;
endmodule

// File: rtl/vmask_permute.sv
`timescale 1ns/1ps
module vmask_permute
    import vmp_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 16,
    localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int LEN_W = $clog2(NUM_ELEM + 1),
    localparam int VEC_W = NUM_ELEM * ELEM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                op_sel,
    input  logic [LEN_W-1:0]    vec_len,
    input  logic [NUM_ELEM-1:0] mask,
    input  logic [VEC_W-1:0]    src_vec,
    input  logic [VEC_W-1:0]    fill_vec,
    output logic [VEC_W-1:0]    result,
    output logic [LEN_W-1:0]    packed_len,
    output logic                done
);
    logic                load, step, running;
    logic [IDX_W-1:0]    idx;
    logic [NUM_ELEM-1:0] eff_mask;

    vmp_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .idx(idx),
        .running(running), .done(done)
    );

    vmp_vl_mask #(.NUM_ELEM(NUM_ELEM)) u_vlmask (
        .vec_len(vec_len), .mask(mask), .eff_mask(eff_mask)
    );

    vmp_datapath #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .idx(idx),
        .op_in(vmp_op_e'(op_sel)), .eff_mask(eff_mask),
        .src_flat(src_vec), .fill_flat(fill_vec),
        .result_flat(result), .packed_len(packed_len)
    );
endmodule

// File: rtl/vmp_checker.sv
`timescale 1ns/1ps
module vmp_checker #(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 16,
    localparam int LEN_W = $clog2(NUM_ELEM + 1),
    localparam int VEC_W = NUM_ELEM * ELEM_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             running,
    input logic             done,
    input logic [LEN_W-1:0] packed_len,
    input logic [VEC_W-1:0] result
);
    logic [LEN_W-1:0] chk_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  chk_cnt <= '0;
        else if (chk_cnt != '0)      chk_cnt <= chk_cnt - LEN_W'(1);
        else if (start && !running)  chk_cnt <= LEN_W'(NUM_ELEM);
    end

    // R7
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_cnt == LEN_W'(1)) |=> done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    quiet_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_cnt > LEN_W'(1)) |=> !done);

    // R3
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        packed_len <= LEN_W'(NUM_ELEM));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> ($stable(result) && $stable(packed_len)));
endmodule

bind vmask_permute vmp_checker #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_vmp_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .running(running),
    .done(done), .packed_len(packed_len), .result(result)
);

// File: tb/test_vmask_permute.sv
`timescale 1ns/1ps
module test_vmask_permute;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int LW = $clog2(N + 1);
    localparam int VW = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_sel = 1'b0;
    logic [LW-1:0] vec_len = '0;
    logic [N-1:0]  mask = '0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] fill_vec = '0;
    logic [VW-1:0] result;
    logic [LW-1:0] packed_len;
    logic          done;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R10";
    bit    finished = 0;

    // reference model state
    int            mcnt  = 0;
    bit            mdone = 0;
    logic [VW-1:0] exp_vec = '0;
    int            exp_len = 0;

    always #4 clk = ~clk;

    vmask_permute #(.NUM_ELEM(N), .ELEM_W(W)) i_vmask_permute (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .vec_len(vec_len), .mask(mask), .src_vec(src_vec), .fill_vec(fill_vec),
        .result(result), .packed_len(packed_len), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [VW-1:0] mk_vec(input int base);
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(base + 7 * i);
        return v;
    endfunction

    // behavioural reference: queue of selected elements
    task automatic model_compute();
        int q[$];
        int k;
        exp_vec = '0;
        if (op_sel == 1'b0) begin
            for (int i = 0; i < N; i++)
                if (mask[i] && (i < int'(vec_len))) q.push_back(int'(src_vec[i*W +: W]));
            for (int j = 0; j < q.size(); j++) exp_vec[j*W +: W] = W'(q[j]);
            exp_len = q.size();
        end else begin
            k = 0;
            for (int i = 0; i < N; i++) begin
                if (mask[i] && (i < int'(vec_len))) begin
                    exp_vec[i*W +: W] = src_vec[k*W +: W];
                    k++;
                end else begin
                    exp_vec[i*W +: W] = fill_vec[i*W +: W];
                end
            end
            exp_len = k;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt  = 0;
            mdone = 0;
        end else begin
            mdone = 0;
            if (mcnt > 0) begin
                mcnt--;
                if (mcnt == 0) mdone = 1;
            end else if (start) begin
                model_compute();
                mcnt = N;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(done == mdone, "R7", "done", VW'(done), VW'(mdone));
            if (mdone) begin
                chk(result == exp_vec, cur_tag, "result", result, exp_vec);
                chk(int'(packed_len) == exp_len, "R3", "packed_len", VW'(packed_len), VW'(exp_len));
            end
        end
    end

    task automatic launch(input bit op, input int vl, input logic [N-1:0] m,
                          input int sbase, input int fbase);
        @(negedge clk);
        op_sel   = op;
        vec_len  = LW'(vl);
        mask     = m;
        src_vec  = mk_vec(sbase);
        fill_vec = mk_vec(fbase);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_op(input string tag, input bit op, input int vl,
                         input logic [N-1:0] m, input int sbase, input int fbase);
        cur_tag = tag;
        launch(op, vl, m, sbase, fbase);
        repeat (N + 4) @(negedge clk);
        // R12: result holds while idle
        chk(result == exp_vec, "R12", "held result", result, exp_vec);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk(done == 1'b0, "R10", "done after reset", VW'(done), '0);
        chk(result == '0, "R10", "result after reset", result, '0);
        chk(packed_len == '0, "R10", "packed_len after reset", VW'(packed_len), '0);

        do_op("R1", 1'b0, 8, 8'hFF, 16'h100, 0);
        do_op("R2", 1'b0, 8, 8'b1011_0010, 16'h200, 0);
        do_op("R4", 1'b1, 8, 8'b1011_0010, 16'h300, 16'h900);
        do_op("R5", 1'b1, 8, 8'b0100_1001, 16'h400, 16'hA00);
        do_op("R11", 1'b0, 8, 8'h00, 16'h500, 16'hB00);
        do_op("R11", 1'b1, 8, 8'h00, 16'h500, 16'hB00);
        do_op("R6", 1'b0, 5, 8'hFF, 16'h600, 0);
        do_op("R6", 1'b1, 3, 8'b1110_0110, 16'h700, 16'hC00);
        do_op("R6", 1'b0, 15, 8'b1000_0001, 16'h800, 0);

        // R8: second start while running must be ignored
        cur_tag = "R8";
        launch(1'b0, 8, 8'b0110_0101, 16'h1000, 0);
        @(negedge clk);
        op_sel = 1'b1; mask = 8'hF0; src_vec = mk_vec(16'h2000); fill_vec = mk_vec(16'h3000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 4) @(negedge clk);
        chk(result == exp_vec, "R8", "result after ignored start", result, exp_vec);

        // R9: start in the done cycle begins a new operation
        cur_tag = "R9";
        launch(1'b1, 8, 8'b0011_1100, 16'h4000, 16'h5000);
        while (!done) @(negedge clk);
        op_sel = 1'b0; vec_len = LW'(8); mask = 8'b1100_0011; src_vec = mk_vec(16'h6000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 4) @(negedge clk);
        chk(result == exp_vec, "R9", "back-to-back result", result, exp_vec);
        chk(int'(packed_len) == 4, "R9", "back-to-back length", VW'(packed_len), VW'(4));

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule